// File: doc/BRIEF.md
# Memory Range CRC Scanner

This block computes a 16-bit CRC over a region of a word-organised code memory. A control write carries a start bit and a range code that picks how many fixed-size blocks to cover, always starting at word 0. The engine then drives a synchronous memory read port with one 32-bit word address per clock. It folds each returned word into the CRC in a single cycle, so a 64 KB range at 32 MHz completes in about half a millisecond. While the scan runs, a stall output holds off the requester. When it ends, a one-cycle completion interrupt fires and the final CRC sits in a result register until the next scan completes.

A second, byte-wide path shares the same CRC accumulator. Software can clear it and then stream bytes back to back, with one byte folded at each accepting clock edge. The scan owns the accumulator while it runs, so byte writes and clears are refused during that time.

The CRC uses generator x^16 + x^12 + x^5 + 1 (0x1021), seed 0x0000, and no final inversion. Bits within a byte are taken most significant first, and the bytes of each memory word are taken from the lowest address up.

Top module: `crc_range_scanner`

## Requirements
- R1: The scan result equals the CRC with polynomial 0x1021, seed 0x0000, MSB-first bits, over the scanned bytes in ascending address order, where byte k of word w is mem_rdata[8k+7:8k].
- R2: Range code r (taken from ctl_range when a start is accepted) scans words 0 to (r+1)*BLOCK_WORDS-1, each read exactly once, in increasing address order with no gaps. Codes at or above NUM_BLOCKS are clamped to the full range.
- R3: One word is consumed per clock: scan_busy is high for exactly N+1 cycles for an N-word scan.
- R4: scan_result changes only at the edge that raises scan_done_irq. Byte-port activity leaves it unchanged.
- R5: scan_done_irq is a single-cycle pulse. It goes high in the first cycle in which scan_busy is low again.
- R6: A start request (ctl_wr with ctl_start high) that arrives while scan_busy is high is ignored. It affects neither the range nor the result nor the duration.
- R7: scan_busy and req_stall rise in the cycle after an accepted start and stay high until completion. mem_rd_en is only high while busy.
- R8: With scan_busy low, byte_wr folds byte_data into crc_acc at that clock edge, so bytes can be streamed back to back. byte_clr loads the seed 0x0000 and takes priority over byte_wr.
- R9: byte_wr and byte_clr are ignored while scan_busy is high.
- R10: After reset, scan_busy, req_stall, scan_done_irq and mem_rd_en are low, and scan_result and crc_acc are 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start bit of the control write |
| ctl_range | input | RANGE_W | Range code: number of blocks minus one |
| scan_busy | output | 1 | Scan in progress |
| req_stall | output | 1 | Stall to the requester while scanning |
| scan_done_irq | output | 1 | One-cycle completion interrupt |
| scan_result | output | 16 | CRC of the last completed scan |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | WADDR_W | Word address of the read |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| byte_wr | input | 1 | Fold byte_data into the accumulator |
| byte_clr | input | 1 | Reload the accumulator with the seed |
| byte_data | input | 8 | Byte for the byte path |
| crc_acc | output | 16 | Shared CRC accumulator |

## Verification
Every range code is combined with four memory contents:
- All-zero words give a zero CRC, which only shows that the words were read.
- All-ones words expose seed and length mistakes, because the CRC of constant data depends on how many bytes were folded.
- A multiplicative address hash makes every word distinct, so a skipped, repeated or reordered word or byte lane changes the result.
- A walking single bit checks each bit position and the MSB-first order.

On the byte path, the bench compares the accumulator against a bit-serial reference after every streamed byte, including the well-known nine-digit ASCII check string. A second scan is also run with byte writes and a second start injected mid-scan, to show that neither disturbs the result or the duration.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

   localparam logic [15:0] CRC_POLY = 16'h1021;
   localparam logic [15:0] CRC_SEED = 16'h0000;

   // One byte folded MSB first into a 16-bit CRC.
   function automatic logic [15:0] crc_step_byte(input logic [15:0] crc_in,
                                                 input logic [7:0]  din);
      logic [15:0] r;
      r = crc_in ^ {din, 8'h00};
      for (int i = 0; i < 8; i++) begin
         if (r[15]) r = {r[14:0], 1'b0} ^ CRC_POLY;
         else       r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

endpackage

// File: rtl/crc_word_fold.sv
module crc_word_fold #(
   parameter int NBYTES         = 4,
   parameter bit LANE_ASCENDING = 1'b1
) (
   input  logic [15:0]         crc_in,
   input  logic [8*NBYTES-1:0] word_in,
   output logic [15:0]         crc_out
);
   import crc_scan_pkg::*;

   if (NBYTES < 1) begin : g_bad_nbytes
      $error("crc_word_fold: NBYTES must be at least 1");
   end

   logic [15:0] chain [NBYTES+1];
   assign chain[0] = crc_in;

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      if (LANE_ASCENDING) begin : g_asc
         assign chain[g+1] = crc_step_byte(chain[g], word_in[8*g +: 8]);
      end else begin : g_desc
         assign chain[g+1] = crc_step_byte(chain[g], word_in[8*(NBYTES-1-g) +: 8]);
      end
   end

   assign crc_out = chain[NBYTES];

endmodule

// File: rtl/crc_scan_ctrl.sv
module crc_scan_ctrl #(
   parameter int RANGE_W     = 2,
   parameter int BLOCK_WORDS = 4096,
   parameter int NUM_BLOCKS  = 4,
   parameter int WADDR_W     = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_req,
   input  logic [RANGE_W-1:0] range_code,
   output logic               start_ok,
   output logic               busy,
   output logic               rd_en,
   output logic [WADDR_W-1:0] rd_addr,
   output logic               data_valid,
   output logic               data_last,
   output logic               done
);
   logic               busy_q, rd_en_q, rvalid_q, rlast_q, done_q;
   logic [WADDR_W-1:0] addr_q, last_q, last_word;
   logic               at_last;
   int                 eff_blocks;

   assign start_ok = start_req && !busy_q;
   assign at_last  = (addr_q == last_q);

   always_comb begin
      if (int'(range_code) >= NUM_BLOCKS) eff_blocks = NUM_BLOCKS;
      else                                eff_blocks = int'(range_code) + 1;
      last_word = WADDR_W'(eff_blocks * BLOCK_WORDS - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         rd_en_q  <= 1'b0;
         addr_q   <= '0;
         last_q   <= '0;
         rvalid_q <= 1'b0;
         rlast_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         rvalid_q <= rd_en_q;
         rlast_q  <= rd_en_q && at_last;
         if (start_ok) begin
            busy_q  <= 1'b1;
            rd_en_q <= 1'b1;
            addr_q  <= '0;
            last_q  <= last_word;
         end else begin
            if (rd_en_q) begin
               if (at_last) rd_en_q <= 1'b0;
               else         addr_q  <= addr_q + 1'b1;
            end
            if (rvalid_q && rlast_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy       = busy_q;
   assign rd_en      = rd_en_q;
   assign rd_addr    = addr_q;
   assign data_valid = rvalid_q;
   assign data_last  = rlast_q;
   assign done       = done_q;

endmodule

// File: rtl/crc_accum.sv
module crc_accum #(
   parameter int WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scan_seed,
   input  logic                    scan_fold,
   input  logic                    scan_busy,
   input  logic [8*WORD_BYTES-1:0] scan_word,
   input  logic                    byte_wr,
   input  logic                    byte_clr,
   input  logic [7:0]              byte_data,
   output logic [15:0]             word_next,
   output logic [15:0]             crc_q
);
   import crc_scan_pkg::*;

   logic [15:0] acc_q, byte_next;

   crc_word_fold #(.NBYTES(WORD_BYTES), .LANE_ASCENDING(1'b1)) u_word_fold (
      .crc_in (acc_q),
      .word_in(scan_word),
      .crc_out(word_next)
   );

   crc_word_fold #(.NBYTES(1), .LANE_ASCENDING(1'b1)) u_byte_fold (
      .crc_in (acc_q),
      .word_in(byte_data),
      .crc_out(byte_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       acc_q <= CRC_SEED;
      else if (scan_seed)               acc_q <= CRC_SEED;
      else if (scan_fold)               acc_q <= word_next;
      else if (!scan_busy && byte_clr)  acc_q <= CRC_SEED;
      else if (!scan_busy && byte_wr)   acc_q <= byte_next;
   end

   assign crc_q = acc_q;

endmodule

// File: rtl/crc_range_scanner.sv
module crc_range_scanner #(
   parameter int RANGE_W     = 2,
   parameter int BLOCK_WORDS = 4096,
   parameter int NUM_BLOCKS  = 4,
   parameter int WORD_BYTES  = 4,
   localparam int WADDR_W    = $clog2(BLOCK_WORDS * NUM_BLOCKS),
   localparam int DATA_W     = 8 * WORD_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic               ctl_start,
   input  logic [RANGE_W-1:0] ctl_range,
   output logic               scan_busy,
   output logic               req_stall,
   output logic               scan_done_irq,
   output logic [15:0]        scan_result,
   output logic               mem_rd_en,
   output logic [WADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               byte_wr,
   input  logic               byte_clr,
   input  logic [7:0]         byte_data,
   output logic [15:0]        crc_acc
);
   if (BLOCK_WORDS * NUM_BLOCKS < 2) begin : g_bad_size
      $error("crc_range_scanner: scan space must hold at least two words");
   end
   if (NUM_BLOCKS > (1 << RANGE_W)) begin : g_bad_range
      $error("crc_range_scanner: RANGE_W too narrow for NUM_BLOCKS");
   end

   logic        start_ok, busy, dvalid, dlast, done;
   logic [15:0] word_next, result_q;

   crc_scan_ctrl #(
      .RANGE_W(RANGE_W), .BLOCK_WORDS(BLOCK_WORDS),
      .NUM_BLOCKS(NUM_BLOCKS), .WADDR_W(WADDR_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (ctl_wr && ctl_start),
      .range_code(ctl_range),
      .start_ok  (start_ok),
      .busy      (busy),
      .rd_en     (mem_rd_en),
      .rd_addr   (mem_addr),
      .data_valid(dvalid),
      .data_last (dlast),
      .done      (done)
   );

   crc_accum #(.WORD_BYTES(WORD_BYTES)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_seed(start_ok),
      .scan_fold(dvalid),
      .scan_busy(busy),
      .scan_word(mem_rdata),
      .byte_wr  (byte_wr),
      .byte_clr (byte_clr),
      .byte_data(byte_data),
      .word_next(word_next),
      .crc_q    (crc_acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                result_q <= 16'h0000;
      else if (dvalid && dlast)  result_q <= word_next;
   end

   assign scan_busy     = busy;
   assign req_stall     = busy;
   assign scan_done_irq = done;
   assign scan_result   = result_q;

endmodule

// File: rtl/crc_range_scanner_chk.sv
module crc_range_scanner_chk #(
   parameter int WADDR_W = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               scan_busy,
   input logic               scan_done_irq,
   input logic [15:0]        scan_result,
   input logic               mem_rd_en,
   input logic [WADDR_W-1:0] mem_addr
);
   a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done_irq |=> !scan_done_irq);

   a_r5_irq_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done_irq |-> (!scan_busy && $past(scan_busy)));

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == WADDR_W'($past(mem_addr) + 1'b1)));

   a_r7_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> scan_busy);

   a_r4_result_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scan_result) |-> scan_done_irq);

endmodule

bind crc_range_scanner crc_range_scanner_chk #(.WADDR_W(WADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scan_busy    (scan_busy),
   .scan_done_irq(scan_done_irq),
   .scan_result  (scan_result),
   .mem_rd_en    (mem_rd_en),
   .mem_addr     (mem_addr)
);

// File: tb/test_crc_range_scanner.sv
module test_crc_range_scanner;
   localparam int RW = 2, BW = 8, NB = 4;
   localparam int AW = $clog2(BW * NB);

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctl_wr = 0, ctl_start = 0, byte_wr = 0, byte_clr = 0;
   logic [RW-1:0] ctl_range = '0;
   logic [7:0] byte_data = '0;
   logic scan_busy, req_stall, scan_done_irq, mem_rd_en;
   logic [15:0] scan_result, crc_acc;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_rdata = '0;

   int checks = 0, fails = 0;
   int pat = 0, rd_count = 0, addr_err = 0, exp_addr = 0;

   always #5 clk = ~clk;

   crc_range_scanner #(.RANGE_W(RW), .BLOCK_WORDS(BW), .NUM_BLOCKS(NB)) i_crc_range_scanner (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_range(ctl_range),
      .scan_busy(scan_busy), .req_stall(req_stall), .scan_done_irq(scan_done_irq),
      .scan_result(scan_result), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .byte_wr(byte_wr), .byte_clr(byte_clr),
      .byte_data(byte_data), .crc_acc(crc_acc));

   function automatic logic [31:0] mem_word(int p, int a);
      case (p)
         0: return 32'h0;
         1: return 32'hFFFF_FFFF;
         2: return 32'(a) * 32'h9E37_79B1 + 32'h0123_4567;
         default: return 32'h1 << (a % 32);
      endcase
   endfunction

   // bit-serial reference
   function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         logic fb;
         fb = c[15] ^ b[i];
         c = c << 1;
         if (fb) c = c ^ 16'h1021;
      end
      return c;
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rdata <= mem_word(pat, int'(mem_addr));
         if (int'(mem_addr) != exp_addr) addr_err <= addr_err + 1;
         exp_addr <= exp_addr + 1;
         rd_count <= rd_count + 1;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_scan(int r, int p, bit inject);
      int n, cyc;
      logic [15:0] e;
      n = (r + 1) * BW;
      e = 16'h0;
      for (int a = 0; a < n; a++)
         for (int k = 0; k < 4; k++) e = ref_byte(e, mem_word(p, a)[8*k +: 8]);
      @(negedge clk);
      pat = p; rd_count = 0; addr_err = 0; exp_addr = 0;
      ctl_wr = 1; ctl_start = 1; ctl_range = RW'(r);
      @(negedge clk);
      ctl_wr = 0; ctl_start = 0; ctl_range = '0;
      chk("R7 busy after start", {scan_busy, req_stall}, 2'b11);
      cyc = 0;
      while (scan_busy && cyc < 1000) begin
         cyc++;
         chk("R5 no irq while busy", scan_done_irq, 0);
         if (inject && cyc == 3) begin
            ctl_wr = 1; ctl_start = 1; ctl_range = '0;   // R6
            byte_wr = 1; byte_data = 8'hA5;             // R9
         end else if (inject && cyc == 4) begin
            ctl_wr = 0; ctl_start = 0; byte_wr = 0; byte_clr = 1;  // R9
         end else begin
            ctl_wr = 0; ctl_start = 0; byte_wr = 0; byte_clr = 0;
         end
         @(negedge clk);
      end
      byte_clr = 0;
      chk(inject ? "R6 R9 result with injected writes" : "R1 scan result", scan_result, e);
      chk("R3 busy cycles", cyc, n + 1);
      chk("R5 irq at busy fall", scan_done_irq, 1);
      chk("R2 read count", rd_count, n);
      chk("R2 address order", addr_err, 0);
      @(negedge clk);
      chk("R5 irq single pulse", scan_done_irq, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] e, held;
      repeat (3) @(negedge clk);
      chk("R10 reset flags", {scan_busy, req_stall, scan_done_irq, mem_rd_en}, 4'b0);
      chk("R10 reset result", scan_result, 16'h0);
      chk("R10 reset acc", crc_acc, 16'h0);
      rst_n = 1;
      for (int r = 0; r < NB; r++)
         for (int p = 0; p < 4; p++) run_scan(r, p, 1'b0);
      run_scan(3, 2, 1'b1);
      run_scan(1, 3, 1'b1);

      // R8 byte streaming, R4 result untouched
      held = scan_result;
      @(negedge clk);
      byte_clr = 1; byte_wr = 1; byte_data = 8'h55;
      @(negedge clk);
      byte_clr = 0;
      chk("R8 clear wins over write", crc_acc, 16'h0);
      e = 16'h0;
      for (int i = 0; i < 9; i++) begin
         byte_wr = 1; byte_data = 8'(8'h31 + i);
         e = ref_byte(e, byte_data);
         @(negedge clk);
         chk("R8 byte stream", crc_acc, e);
      end
      chk("R8 check string", crc_acc, 16'h31C3);
      for (int i = 0; i < 24; i++) begin
         byte_data = 8'(i * 37 + 11);
         e = ref_byte(e, byte_data);
         @(negedge clk);
         chk("R8 byte sweep", crc_acc, e);
      end
      byte_wr = 0;
      @(negedge clk);
      chk("R8 idle hold", crc_acc, e);
      chk("R4 result held after byte use", scan_result, held);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule